// File: doc/BRIEF.md
# Boot-Time ROM Integrity Checker

This controller holds the processor in reset while it proves that the protected boot memory is intact. It walks every data word through a synchronous read port and re-encodes each word with a content-dependent code. A word with few zero bits gets a one-bit even parity. A word with many zero bits gets a seven-bit single-error-correcting, double-error-detecting Hamming code. Each recomputed record (a mode tag plus the code) is compared with the record stored for that word on a separate redundancy read path.

While the data pass runs, the checker folds every word into a column-parity accumulator. After the last data word it reads the stored column-parity word, which sits directly behind the data, and compares the two. If every comparison agrees, the checker raises the processor release and keeps it raised. At the first disagreement it stops reading, raises the alarm, and latches the address that failed. Either final state lasts until the next reset.

Top module: `rom_guard`

## Requirements
- R1: While reset is held, `cpu_release`, `error_alarm`, `mem_rd` and `red_rd` are all 0.
- R2: After reset, data reads go to addresses 0, 1, …, N_WORDS-1 in ascending order. Each data read pairs with a redundancy read at the same address in the same cycle. Then exactly one read of address N_WORDS (the column-parity word) follows, with `red_rd` low.
- R3: A word with fewer than DATA_W/2 zero bits is encoded in parity mode as record `{1'b0, 6'b0, p}`, where p is the XOR of all data bits (bit 7 is the mode tag, 0 = parity).
- R4: A word with DATA_W/2 or more zero bits is encoded in Hamming mode as record `{1'b1, q, c[5:0]}`. Data bit i sits at the i-th codeword position ≥3 that is not a power of two. Check bit c[j] is the XOR of the data bits whose position has bit j set. q is the XOR of all data bits and c[5:0].
- R5: When the recomputed record for word k differs from the stored record in any bit, including the mode tag, the checker raises `error_alarm` with `fail_addr` = k. It makes no read beyond word k.
- R6: The column-parity check passes only if the word at address N_WORDS equals the XOR of all data words. Otherwise `error_alarm` rises with `fail_addr` = N_WORDS.
- R7: `cpu_release` rises only after all N_WORDS+1 reads and all comparisons have matched.
- R8: Once raised, `cpu_release` or `error_alarm` holds until reset, `fail_addr` stays constant, the two are never high together, and no further reads are issued.
- R9: The mode boundary is exact. A word with exactly DATA_W/2 zeros uses Hamming mode, and a word with DATA_W/2-1 zeros uses parity mode. A stored record with the wrong mode for its word fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the check restarts on release |
| mem_addr | output | ADDR_W | Boot memory word address |
| mem_rd | output | 1 | Boot memory read enable |
| mem_rdata | input | DATA_W | Boot memory data, valid one cycle after `mem_rd` |
| red_addr | output | ADDR_W | Stored-redundancy record address |
| red_rd | output | 1 | Stored-redundancy read enable |
| red_rdata | input | REC_W | Stored record {mode tag, code}, valid one cycle after `red_rd` |
| cpu_release | output | 1 | Processor may fetch instructions |
| error_alarm | output | 1 | Integrity failure alarm |
| fail_addr | output | ADDR_W | Address of the failing word, or N_WORDS for the column-parity word |

## Verification
The bench builds the checker with DATA_W = 32 and N_WORDS = 8. This keeps a full pass under twenty cycles, so every failure position and the final column-parity read stay within a short directed run. The 32-bit width gives the six-plus-one-bit Hamming record. It also puts the mode boundary at sixteen zeros, so words with exactly 15 and 16 zeros can be placed on purpose. The bench recomputes every stored record with its own codeword-building routine. It then corrupts code bits, mode tags, data bits and the column-parity word one at a time.

// File: rtl/rom_guard_pkg.sv
package rom_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WORD,
    ST_CMP_WORD,
    ST_RD_SIG,
    ST_CMP_SIG,
    ST_PASS,
    ST_FAIL
  } scan_st_e;

  // Number of Hamming check bits for a data width w.
  function automatic int hamming_bits(input int w);
    int r;
    r = 1;
    for (int p = 1; p < 31; p++) begin
      if ((1 << p) >= w + p + 1) begin
        r = p;
        break;
      end
    end
    return r;
  endfunction

  function automatic int record_bits(input int w);
    return hamming_bits(w) + 2;
  endfunction

endpackage

// File: rtl/rg_word_enc.sv
module rg_word_enc #(
  parameter int DATA_W = 32,
  localparam int HB_W  = rom_guard_pkg::hamming_bits(DATA_W),
  localparam int CODE_W = HB_W + 1,
  localparam int REC_W = CODE_W + 1,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] word,
  output logic [REC_W-1:0]  rec,
  output logic [CNT_W-1:0]  zeros,
  output logic              ecc_mode
);

  localparam int HALF = DATA_W / 2;
  localparam int TOP_POS = DATA_W + HB_W;

  function automatic logic [CNT_W-1:0] count_zeros(input logic [DATA_W-1:0] d);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + CNT_W'(~d[i]);
    return n;
  endfunction

  function automatic logic [HB_W-1:0] check_bits(input logic [DATA_W-1:0] d);
    logic [HB_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int pos = 3; pos <= TOP_POS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int j = 0; j < HB_W; j++)
          if (((pos >> j) & 1) == 1) c[j] = c[j] ^ d[k];
        k++;
      end
    end
    return c;
  endfunction

  function automatic logic [CODE_W-1:0] secded_code(input logic [DATA_W-1:0] d);
    logic [HB_W-1:0] c;
    c = check_bits(d);
    return {(^d) ^ (^c), c};
  endfunction

  function automatic logic [CODE_W-1:0] parity_code(input logic [DATA_W-1:0] d);
    return {{(CODE_W-1){1'b0}}, ^d};
  endfunction

  always_comb begin
    zeros    = count_zeros(word);
    ecc_mode = (zeros >= CNT_W'(HALF));
    rec      = ecc_mode ? {1'b1, secded_code(word)} : {1'b0, parity_code(word)};
  end

endmodule

// File: rtl/rg_col_acc.sv
module rg_col_acc #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc ^ din;
  end

  // R6: the column accumulator starts each pass from zero
  p_acc_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));

endmodule

// File: rtl/rg_scan_seq.sv
module rg_scan_seq #(
  parameter int N_WORDS = 17,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_ok,
  input  logic              sig_ok,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              rec_rd,
  output logic              acc_clr,
  output logic              acc_en,
  output logic              cpu_release,
  output logic              error_alarm,
  output logic [ADDR_W-1:0] fail_addr
);
  import rom_guard_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(N_WORDS - 1);
  localparam logic [ADDR_W-1:0] SIG_ADDR = ADDR_W'(N_WORDS);

  scan_st_e          state, nxt;
  logic [ADDR_W-1:0] idx;
  logic              last_word;
  logic              word_bad;
  logic              sig_bad;

  assign last_word = (idx == LAST_IDX);
  assign word_bad  = (state == ST_CMP_WORD) && !word_ok;
  assign sig_bad   = (state == ST_CMP_SIG) && !sig_ok;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     nxt = ST_RD_WORD;
      ST_RD_WORD:  nxt = ST_CMP_WORD;
      ST_CMP_WORD: nxt = !word_ok ? ST_FAIL : (last_word ? ST_RD_SIG : ST_RD_WORD);
      ST_RD_SIG:   nxt = ST_CMP_SIG;
      ST_CMP_SIG:  nxt = sig_ok ? ST_PASS : ST_FAIL;
      ST_PASS:     nxt = ST_PASS;
      ST_FAIL:     nxt = ST_FAIL;
      default:     nxt = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      fail_addr <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE) idx <= '0;
      else if (state == ST_CMP_WORD && word_ok && !last_word) idx <= idx + 1'b1;
      if (word_bad)     fail_addr <= idx;
      else if (sig_bad) fail_addr <= SIG_ADDR;
    end
  end

  assign mem_addr    = (state == ST_RD_SIG) ? SIG_ADDR : idx;
  assign mem_rd      = (state == ST_RD_WORD) || (state == ST_RD_SIG);
  assign rec_rd      = (state == ST_RD_WORD);
  assign acc_clr     = (state == ST_IDLE);
  assign acc_en      = (state == ST_CMP_WORD);
  assign cpu_release = (state == ST_PASS);
  assign error_alarm = (state == ST_FAIL);

  // R2: each accepted word is followed by a read of the next address
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMP_WORD && word_ok && !last_word)
      |=> (mem_rd && rec_rd && mem_addr == $past(mem_addr) + 1'b1));

  // R5: a word mismatch raises the alarm with that word's address
  p_word_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |=> (error_alarm && fail_addr == $past(mem_addr)));

  // R7: release only follows a matching column-parity comparison
  p_release_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_release) |-> $past(state == ST_CMP_SIG && sig_ok));

  // R8: final states are exclusive, sticky and quiet
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_release && error_alarm));
  p_pass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_release |=> cpu_release);
  p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error_alarm |=> (error_alarm && $stable(fail_addr)));
  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_release || error_alarm) |-> !mem_rd && !rec_rd);

endmodule

// File: rtl/rom_guard.sv
module rom_guard #(
  parameter int N_WORDS = 17,
  parameter int DATA_W  = 32,
  localparam int ADDR_W = $clog2(N_WORDS + 1),
  localparam int REC_W  = rom_guard_pkg::record_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] red_addr,
  output logic              red_rd,
  input  logic [REC_W-1:0]  red_rdata,
  output logic              cpu_release,
  output logic              error_alarm,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [REC_W-1:0]  calc_rec;
  logic [CNT_W-1:0]  zero_cnt;
  logic              calc_ecc;
  logic [DATA_W-1:0] col_acc;
  logic              acc_clr, acc_en;
  logic              word_ok, sig_ok;

  rg_word_enc #(.DATA_W(DATA_W)) u_enc (
    .word     (mem_rdata),
    .rec      (calc_rec),
    .zeros    (zero_cnt),
    .ecc_mode (calc_ecc)
  );

  rg_col_acc #(.DATA_W(DATA_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acc_clr),
    .en    (acc_en),
    .din   (mem_rdata),
    .acc   (col_acc)
  );

  // Full record compare: a differing mode tag is a mismatch by itself.
  assign word_ok = (calc_rec == red_rdata);
  assign sig_ok  = (col_acc == mem_rdata);

  rg_scan_seq #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_ok     (word_ok),
    .sig_ok      (sig_ok),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .rec_rd      (red_rd),
    .acc_clr     (acc_clr),
    .acc_en      (acc_en),
    .cpu_release (cpu_release),
    .error_alarm (error_alarm),
    .fail_addr   (fail_addr)
  );

  assign red_addr = mem_addr;

  // R3: a word read in parity mode never carries a Hamming-mode tag
  p_mode_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && word_ok && !calc_ecc) |-> !red_rdata[REC_W-1]);

  // R9: the boundary case of exactly DATA_W/2 zeros is accepted only with a Hamming tag
  p_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && word_ok && zero_cnt == CNT_W'(DATA_W / 2)) |-> red_rdata[REC_W-1]);

endmodule

// File: tb/sim_rom_guard.sv
module sim_rom_guard;
  localparam int N = 8;
  localparam int W = 32;
  localparam int AW = $clog2(N + 1);
  localparam int RW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] mem_addr, red_addr, fail_addr;
  logic mem_rd, red_rd, cpu_release, error_alarm;
  logic [W-1:0] mem_rdata = '0;
  logic [RW-1:0] red_rdata = '0;

  logic [W-1:0]  mem [0:N];
  logic [RW-1:0] red [0:N-1];

  int n_chk = 0, n_bad = 0;
  int reads = 0, exp_next = 0, order_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rom_guard #(.N_WORDS(N), .DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .red_addr(red_addr), .red_rd(red_rd), .red_rdata(red_rdata),
    .cpu_release(cpu_release), .error_alarm(error_alarm), .fail_addr(fail_addr)
  );

  always @(posedge clk) begin
    if (mem_rd && mem_addr <= AW'(N)) mem_rdata <= mem[mem_addr];
    if (red_rd && red_addr < AW'(N))  red_rdata <= red[red_addr];
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      reads = 0; exp_next = 0; order_bad = 0;
    end else if (mem_rd) begin
      if (int'(mem_addr) != exp_next) order_bad++;
      if (exp_next < N && (!red_rd || red_addr != mem_addr)) order_bad++;
      if (exp_next == N && red_rd) order_bad++;
      exp_next++;
      reads++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench encoding: build an explicit codeword, then derive checks from it.
  function automatic logic [7:0] enc(input logic [W-1:0] d);
    logic cw [1:38];
    logic [5:0] c;
    int k;
    if ($countones(~d) < W / 2) return {7'b0, ^d};
    k = 0;
    for (int p = 1; p <= 38; p++) begin
      if ($countones(p) == 1 || p < 3) cw[p] = 1'b0;
      else begin cw[p] = d[k]; k++; end
    end
    c = '0;
    for (int p = 1; p <= 38; p++)
      for (int j = 0; j < 6; j++)
        if (p[j]) c[j] ^= cw[p];
    return {1'b1, (^d) ^ (^c), c};
  endfunction

  function automatic logic [W-1:0] with_zeros(input int k, input int rot);
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < k; i++) m[(i + rot) % W] = 1'b1;
    return ~m;
  endfunction

  task automatic program_all();
    logic [W-1:0] x;
    x = '0;
    for (int i = 0; i < N; i++) begin
      red[i] = enc(mem[i]);
      x ^= mem[i];
    end
    mem[N] = x;
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: mem[i] = $urandom | $urandom | $urandom;
        1: mem[i] = $urandom & $urandom & $urandom;
        default: mem[i] = with_zeros((i % 2 == 0) ? W / 2 : W / 2 - 1, i * 5);
      endcase
    end
    program_all();
  endtask

  task automatic run_scan();
    int n;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    n = 0;
    while (!(cpu_release || error_alarm) && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_pass(input string req);
    run_scan();
    chk(cpu_release === 1'b1, req, "release", int'(cpu_release), 1);
    chk(error_alarm === 1'b0, req, "alarm", int'(error_alarm), 0);
    chk(reads == N + 1, "R7", "reads before release", reads, N + 1);
    chk(order_bad == 0, "R2", "read order errors", order_bad, 0);
  endtask

  task automatic expect_fail(input string req, input int at);
    run_scan();
    chk(error_alarm === 1'b1, req, "alarm", int'(error_alarm), 1);
    chk(cpu_release === 1'b0, req, "release", int'(cpu_release), 0);
    chk(int'(fail_addr) == at, req, "fail_addr", int'(fail_addr), at);
    chk(reads == at + 1, req, "reads up to failure", reads, at + 1);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(cpu_release === 1'b0, "R1", "release in reset", int'(cpu_release), 0);
    chk(error_alarm === 1'b0, "R1", "alarm in reset", int'(error_alarm), 0);
    chk(mem_rd === 1'b0 && red_rd === 1'b0, "R1", "reads in reset", int'(mem_rd) + int'(red_rd), 0);
  endtask

  task automatic t_dense_pass();   fill(0); expect_pass("R3"); endtask
  task automatic t_sparse_pass();  fill(1); expect_pass("R4"); endtask
  task automatic t_boundary();
    fill(2); expect_pass("R9");
    red[4] = {7'b0, ^mem[4]};          // 16-zero word given a parity record
    expect_fail("R9", 4);
  endtask
  task automatic t_bad_code();  fill(1); red[3][0] = ~red[3][0]; expect_fail("R5", 3); endtask
  task automatic t_bad_tag();   fill(0); red[5][7] = ~red[5][7]; expect_fail("R5", 5); endtask
  task automatic t_bad_data();  fill(1); mem[2] = mem[2] ^ 32'h0000_0101; expect_fail("R4", 2); endtask
  task automatic t_bad_sig();   fill(0); mem[N][9] = ~mem[N][9]; expect_fail("R6", N); endtask
  task automatic t_first_last();
    fill(1); red[0][7] = ~red[0][7]; expect_fail("R5", 0);
    fill(0); red[N-1][0] = ~red[N-1][0]; expect_fail("R5", N - 1);
  endtask

  task automatic t_hold();
    int r0;
    fill(1); expect_pass("R8");
    r0 = reads;
    repeat (30) @(negedge clk);
    chk(cpu_release === 1'b1 && error_alarm === 1'b0, "R8", "release held", int'(cpu_release), 1);
    chk(reads == r0, "R8", "reads after release", reads, r0);
    fill(0); mem[N] = ~mem[N]; expect_fail("R8", N);
    r0 = reads;
    repeat (30) @(negedge clk);
    chk(error_alarm === 1'b1 && cpu_release === 1'b0, "R8", "alarm held", int'(error_alarm), 1);
    chk(int'(fail_addr) == N, "R8", "fail_addr held", int'(fail_addr), N);
    chk(reads == r0, "R8", "reads after alarm", reads, r0);
  endtask

  initial begin
    t_reset();
    t_dense_pass();
    t_sparse_pass();
    t_boundary();
    t_bad_code();
    t_bad_tag();
    t_bad_data();
    t_bad_sig();
    t_first_last();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule